// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block watches a bank of 32 already-synchronized general-purpose input pins and turns selected pin activity into interrupt requests. Every pin owns a 4-bit sense code that chooses what counts as an event: a rising edge, a falling edge, a high level, a low level, or any change. Edges are found by comparing each pin with the value it had one clock earlier. An event on a pin whose input-enable bit is set raises that pin's pending bit, which stays set until software clears it.

A separate interrupt mask chooses which pending bits reach the two interrupt outputs. Software sets mask bits through one write-only-ones port and clears them through another. One register shows every pending bit and another shows only the unmasked ones. Software writes ones to a clear register to acknowledge bits, normally starting with the lowest set bit. Two interrupt lines cover the lower and the upper half of the pins. All access goes through a simple 32-bit register port with a single-cycle write strobe and a read path with no wait states.

Top module: `gpio_irq_sense`

## Requirements
- R1: Sense codes live in four read/write words at offsets 0x40, 0x44, 0x48 and 0x4C. Pin n uses word n/8 and bits [(n mod 8)*4 +: 4]. Every word reads back exactly what was written.
- R2: The sense code values are: 8 = rising edge (pin 1 now, 0 in the previous cycle), 9 = falling edge, 10 = high level, 11 = low level, 12 = any change. An event seen at a clock edge shows in the pending bit right after that edge.
- R3: Any sense code outside 8..12 never sets the pin's pending bit, whatever the pin does.
- R4: The input-enable word at 0x14 is read/write. A pin whose enable bit is 0 never sets its pending bit.
- R5: Writing ones to 0x18 unmasks those pins and writing ones to 0x1C masks them. Zero bits in either write leave the mask unchanged. Reading either offset returns the unmask bits (1 = unmasked).
- R6: Offset 0x20 reads all pending bits, whatever the mask. Offset 0x24 reads pending AND unmasked.
- R7: Writing a 1 to bit n of 0x28 clears pending bit n. If an enabled event on pin n occurs in the same cycle, the bit stays set, so a level-sensitive pin that is still active becomes pending again at once.
- R8: irq_lo_o is the OR of masked status bits 0..15 and irq_hi_o is the OR of bits 16..31.
- R9: After reset, the sense, enable, mask and pending state are all 0 and both interrupt outputs are low. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Synchronized pin levels |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_lo_o | output | 1 | Interrupt for pins 0..15 |
| irq_hi_o | output | 1 | Interrupt for pins 16..31 |

## Verification
A write-one-to-clear on a pending bit can land in the same cycle as a fresh enabled event on the same pin. The design must then keep the bit set. The bench provokes this on purpose by clearing a high-level pin while it is still high. It also provokes it at random by mixing clear writes with pin activity on every cycle. After each cycle the bench compares the raw and masked pending words with a model in which a new event wins over the clear. A second collision is a sense or enable rewrite in the same cycle as an event. It is judged on the rule that the event is qualified by the settings held before the write.

// File: rtl/gis_pkg.sv
package gis_pkg;
    localparam logic [7:0] OFS_GATE     = 8'h14;
    localparam logic [7:0] OFS_UNM_SET  = 8'h18;
    localparam logic [7:0] OFS_UNM_CLR  = 8'h1C;
    localparam logic [7:0] OFS_PEND_RAW = 8'h20;
    localparam logic [7:0] OFS_PEND_MSK = 8'h24;
    localparam logic [7:0] OFS_PEND_ACK = 8'h28;
    localparam logic [7:0] OFS_SENSE0   = 8'h40;

    typedef enum logic [3:0] {
        SNS_RISE = 4'd8,
        SNS_FALL = 4'd9,
        SNS_HIGH = 4'd10,
        SNS_LOW  = 4'd11,
        SNS_ANY  = 4'd12
    } sense_e;
endpackage

// File: rtl/gis_event_det.sv
module gis_event_det
    import gis_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pin_i,
    input  logic [NPINS*4-1:0] sense_i,
    output logic [NPINS-1:0]   evt_o
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [3:0] code;
        logic       cur, prv;
        assign code = sense_i[i*4 +: 4];
        assign cur  = pin_i[i];
        assign prv  = st_q.prev[i];

        always_comb begin
            case (code)
                SNS_RISE: evt_o[i] = cur & ~prv;
                SNS_FALL: evt_o[i] = ~cur & prv;
                SNS_HIGH: evt_o[i] = cur;
                SNS_LOW:  evt_o[i] = ~cur;
                SNS_ANY:  evt_o[i] = cur ^ prv;
                default:  evt_o[i] = 1'b0;
            endcase
        end

        // R3
        sense_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((code < 4'd8) || (code > 4'd12)) |-> !evt_o[i]);
    end
endmodule

// File: rtl/gis_pending.sv
module gis_pending #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt_i,
    input  logic [NPINS-1:0] gate_i,
    input  logic [NPINS-1:0] ack_i,
    output logic [NPINS-1:0] pend_o
);
    typedef struct packed {
        logic [NPINS-1:0] pend;
    } pnd_st_t;

    pnd_st_t st_d, st_q;
    logic [NPINS-1:0] raise;

    always_comb begin
        raise     = evt_i & gate_i;
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~ack_i) | raise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R4
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & ~$past(pend_o) & ~$past(gate_i)) == '0));

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & $past(ack_i) & ~$past(evt_i & gate_i)) == '0));
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
    import gis_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] pin_i,
    input  logic        reg_wr_i,
    input  logic [7:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        irq_lo_o,
    output logic        irq_hi_o
);
    localparam int NWORDS = NPINS / 8;
    localparam int HALF   = NPINS / 2;

    typedef struct packed {
        logic [NPINS-1:0]   gate;
        logic [NPINS-1:0]   unmask;
        logic [NPINS*4-1:0] sense;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NPINS-1:0] evt, pend, ack, status;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr_i) begin
            if (reg_addr_i == OFS_GATE)    cfg_d.gate   = reg_wdata_i[NPINS-1:0];
            if (reg_addr_i == OFS_UNM_SET) cfg_d.unmask = cfg_q.unmask | reg_wdata_i[NPINS-1:0];
            if (reg_addr_i == OFS_UNM_CLR) cfg_d.unmask = cfg_q.unmask & ~reg_wdata_i[NPINS-1:0];
            for (int j = 0; j < NWORDS; j++) begin
                if (reg_addr_i == OFS_SENSE0 + 8'(4*j))
                    cfg_d.sense[j*32 +: 32] = reg_wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ack = (reg_wr_i && reg_addr_i == OFS_PEND_ACK) ? reg_wdata_i[NPINS-1:0] : '0;

    gis_event_det #(.NPINS(NPINS)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i[NPINS-1:0]),
        .sense_i(cfg_q.sense),
        .evt_o  (evt)
    );

    gis_pending #(.NPINS(NPINS)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt),
        .gate_i(cfg_q.gate),
        .ack_i (ack),
        .pend_o(pend)
    );

    assign status   = pend & cfg_q.unmask;
    assign irq_lo_o = |status[HALF-1:0];
    assign irq_hi_o = |status[NPINS-1:HALF];

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            OFS_GATE:     reg_rdata_o[NPINS-1:0] = cfg_q.gate;
            OFS_UNM_SET,
            OFS_UNM_CLR:  reg_rdata_o[NPINS-1:0] = cfg_q.unmask;
            OFS_PEND_RAW: reg_rdata_o[NPINS-1:0] = pend;
            OFS_PEND_MSK: reg_rdata_o[NPINS-1:0] = status;
            default: begin
                for (int j = 0; j < NWORDS; j++) begin
                    if (reg_addr_i == OFS_SENSE0 + 8'(4*j))
                        reg_rdata_o = cfg_q.sense[j*32 +: 32];
                end
            end
        endcase
    end

    // R5
    unmask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_UNM_SET) |=>
        ((cfg_q.unmask & $past(reg_wdata_i[NPINS-1:0])) == $past(reg_wdata_i[NPINS-1:0])));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.unmask == '0) |-> (!irq_lo_o && !irq_hi_o));

    for (genvar i = 0; i < NPINS; i++) begin : g_lvl
        // R2
        level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q.sense[i*4 +: 4] == SNS_HIGH && pin_i[i] && cfg_q.gate[i]) |=> pend[i]);
    end
endmodule

// File: tb/sim_gpio_irq_sense.sv
`timescale 1ns/100ps
module sim_gpio_irq_sense;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_lo, irq_hi;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] m_gate, m_mask, m_pend, m_prev;
    logic [31:0] m_sense [4];

    always #2.5 clk = ~clk;

    gpio_irq_sense u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
    );

    function automatic logic evt_of(input logic [3:0] c, input logic cur, input logic prv);
        case (c)
            4'd8:    return cur & ~prv;
            4'd9:    return ~cur & prv;
            4'd10:   return cur;
            4'd11:   return ~cur;
            4'd12:   return cur ^ prv;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #0.2;
        check(tag, rdata, exp);
    endtask

    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [31:0] p);
        logic [31:0] ev, clr;
        @(negedge clk);
        wr = w; addr = a; wdata = d; pin = p;
        @(posedge clk);
        ev = '0;
        for (int i = 0; i < 32; i++)
            ev[i] = evt_of(m_sense[i/8][(i%8)*4 +: 4], p[i], m_prev[i]);
        clr = (w && a == 8'h28) ? d : '0;
        m_pend = (m_pend & ~clr) | (ev & m_gate);
        if (w) begin
            if (a == 8'h14) m_gate = d;
            if (a == 8'h18) m_mask = m_mask | d;
            if (a == 8'h1C) m_mask = m_mask & ~d;
            for (int j = 0; j < 4; j++)
                if (a == 8'(8'h40 + 4*j)) m_sense[j] = d;
        end
        m_prev = p;
        #0.5;
        wr = 1'b0;
        rd_chk(8'h20, m_pend, "R6 raw");
        rd_chk(8'h24, m_pend & m_mask, "R6 masked");
        check("R8 irq_lo", {31'd0, irq_lo}, {31'd0, |(m_pend[15:0] & m_mask[15:0])});
        check("R8 irq_hi", {31'd0, irq_hi}, {31'd0, |(m_pend[31:16] & m_mask[31:16])});
    endtask

    function automatic logic [31:0] rnd_sense();
        logic [31:0] w;
        for (int k = 0; k < 8; k++)
            w[k*4 +: 4] = ($urandom % 6 == 0) ? 4'($urandom) : 4'(8 + $urandom % 5);
        return w;
    endfunction

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] p;
        void'($urandom(32'd1357));
        m_gate = '0; m_mask = '0; m_pend = '0; m_prev = '0;
        for (int j = 0; j < 4; j++) m_sense[j] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        step(0, 8'h00, 0, 0);
        rd_chk(8'h14, 0, "R9 gate");
        rd_chk(8'h18, 0, "R9 mask");
        rd_chk(8'h40, 0, "R9 sense0");
        rd_chk(8'h4C, 0, "R9 sense3");
        rd_chk(8'h30, 0, "R9 unmapped");
        check("R9 irq", {30'd0, irq_hi, irq_lo}, 0);

        // R1 pin 13 -> word 0x44 bits 23:20, high level
        step(1, 8'h44, 32'h00A0_0000, 0);
        rd_chk(8'h44, 32'h00A0_0000, "R1 readback");
        step(1, 8'h14, 32'h0000_2000, 0);
        rd_chk(8'h14, 32'h0000_2000, "R4 readback");
        step(1, 8'h18, 32'h0000_2000, 0);
        step(0, 8'h00, 0, 32'h0000_2000);
        check("R2 high level pend", rdata & 32'h2000, 32'h2000);
        check("R8 irq_lo", {31'd0, irq_lo}, 1);
        // R7 clear while level still active re-pends
        step(1, 8'h28, 32'h0000_2000, 32'h0000_2000);
        rd_chk(8'h20, 32'h0000_2000, "R7 level re-pend");
        step(0, 8'h00, 0, 0);
        step(1, 8'h28, 32'h0000_2000, 0);
        rd_chk(8'h20, 0, "R7 cleared");
        // R5 zero write leaves mask
        step(1, 8'h18, 0, 0);
        rd_chk(8'h1C, 32'h0000_2000, "R5 zero no effect");
        step(1, 8'h1C, 32'h0000_2000, 0);
        rd_chk(8'h18, 0, "R5 mask clear");
        // R3 invalid code on pin 2 (word 0x40 bits 11:8 = 5)
        step(1, 8'h40, 32'h0000_0500, 0);
        step(1, 8'h14, 32'h0000_2004, 0);
        step(0, 8'h00, 0, 32'h4);
        step(0, 8'h00, 0, 32'h0);
        rd_chk(8'h20, 0, "R3 invalid code");
        // R4 gate off: pin 20 rising (word 0x48 bits 19:16 = 8) not enabled
        step(1, 8'h48, 32'h0008_0000, 0);
        step(0, 8'h00, 0, 32'h0010_0000);
        rd_chk(8'h20, 0, "R4 gated");
        // R2 rising with gate on, irq_hi
        step(1, 8'h14, 32'h0010_0000, 0);
        step(1, 8'h18, 32'h0010_0000, 0);
        step(0, 8'h00, 0, 32'h0010_0000);
        check("R2 rise irq_hi", {31'd0, irq_hi}, 1);

        // random mix
        p = '0;
        for (int it = 0; it < 3000; it++) begin
            int sel;
            p = p ^ ($urandom & $urandom & $urandom);
            sel = $urandom % 10;
            case (sel)
                0: step(1, 8'h14, $urandom | $urandom, p);
                1: step(1, 8'h18, $urandom, p);
                2: step(1, 8'h1C, $urandom & $urandom, p);
                3, 4: step(1, 8'h28, $urandom, p);
                5: step(1, 8'(8'h40 + 4 * ($urandom % 4)), rnd_sense(), p);
                default: step(0, 8'h00, 0, p);
            endcase
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule